// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable ratio N. It is built from three parts. The first is a dual-modulus prescaler that divides by M or by M+1, with M selectable as 32 or 64. The second is a 7-bit swallow counter (A). The third is an 11-bit main counter (B). During each output period, the prescaler first runs A cycles at M+1 and then runs the remaining B−A cycles at M. The total ratio is therefore N = M·B + A. Once every N input clocks the block emits a pulse one clock wide, which feeds a phase detector.

The ratio setting (A, B and the modulus select) comes from a holding latch outside the block. That setting is sampled only at the end of an output period, and also while reset is held, so a period is never cut short or stretched by a mid-period update. A configuration check runs on each setting as it is taken into use. It raises a flag when B is below A, or when N falls under the continuous-counting floor M·(M−1). While that flag is raised, the divider's output timing is undefined.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `srst` is high, `pulse_out` is low and the ratio inputs are taken into use on every clock. The first pulse appears N clocks after the first rising edge at which `srst` is low.
- R2: With `mode_sel` = 0 (M = 32), `pulse_out` is high for one clock out of every N = 32·B + A clocks.
- R3: With `mode_sel` = 1 (M = 64), `pulse_out` is high for one clock out of every N = 64·B + A clocks.
- R4: `pulse_out` is never high for two clocks in a row.
- R5: In each period, the first A prescaler cycles last M+1 clocks each and the remaining B−A cycles last M clocks each. The prescaler count therefore never goes above M_HI.
- R6: A change to `swallow_a`, `main_b` or `mode_sel` during a period does not affect that period. The value present at the clock edge that ends a period sets the length of the next period. This holds even when the change arrives in the period's last clock.
- R7: `cfg_err` is high exactly when the setting in use has B < A, or has M·B + A < M·(M−1). The flag is updated only when a setting is taken into use.
- R8: The floor settings B = M−1, A = 0 count continuously, giving 992 clocks with M = 32 and 4032 clocks with M = 64. `cfg_err` stays low for both.
- R9: A = B is a valid setting in which every prescaler cycle runs at M+1, giving N = (M+1)·B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divider input clock (the signal being divided) |
| srst | input | 1 | Synchronous reset, active high; loads the ratio inputs |
| mode_sel | input | 1 | Modulus select: 0 gives 32/33, 1 gives 64/65 |
| swallow_a | input | AW | Swallow count A from the holding latch |
| main_b | input | BW | Main count B from the holding latch |
| pulse_out | output | 1 | One-clock pulse once per N input clocks |
| cfg_err | output | 1 | Setting in use is outside the valid range |

## Verification
Two events can fall on the same edge: the end of a period and a change of the ratio inputs. The bench provokes this by waiting until its own model shows one clock left in the period, then driving a new A, B and mode in that very cycle. The new setting must govern the next period, while the finishing pulse still lands on time. The same edge also reloads the swallow counter just as it reaches zero when A = B. A behavioural countdown model compares `pulse_out` and `cfg_err` on every clock to judge both cases.

// File: rtl/pwdiv_pkg.sv
package pwdiv_pkg;
   typedef enum logic {
      MOD_LO = 1'b0,
      MOD_HI = 1'b1
   } modsel_e;
endpackage

// File: rtl/pwdiv_prescaler.sv
module pwdiv_prescaler #(
   parameter int M_LO = 32,
   localparam int M_HI = 2 * M_LO,
   localparam int CW = $clog2(M_HI + 1)
) (
   input  logic clk,
   input  logic srst,
   input  pwdiv_pkg::modsel_e mode,
   input  logic mod_up,
   output logic tc
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;

   always_comb begin
      limit = (mode == pwdiv_pkg::MOD_HI) ? CW'(M_HI - 1) : CW'(M_LO - 1);
      limit = limit + CW'(mod_up);
   end

   assign tc = (cnt_q == limit);

   always_ff @(posedge clk) begin
      if (srst || tc) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

   // R5: longest prescaler cycle is M_HI+1 clocks
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (srst)
      cnt_q <= CW'(M_HI));
endmodule

// File: rtl/pwdiv_counters.sv
module pwdiv_counters #(
   parameter int AW = 7,
   parameter int BW = 11
) (
   input  logic          clk,
   input  logic          srst,
   input  logic          adv,
   input  logic [AW-1:0] a_ld,
   input  logic [BW-1:0] b_ld,
   output logic          mod_up,
   output logic          wrap
);
   logic [AW-1:0] a_q;
   logic [BW-1:0] b_q;
   logic          last;

   assign last   = (b_q == BW'(1));
   assign wrap   = adv && last;
   assign mod_up = (a_q != '0);

   always_ff @(posedge clk) begin
      if (srst || wrap) begin
         a_q <= a_ld;
         b_q <= b_ld;
      end else if (adv) begin
         b_q <= b_q - 1'b1;
         if (a_q != '0) a_q <= a_q - 1'b1;
      end
   end

   // R6: a new period starts from the B value present at the boundary edge
   p_reload_r6: assert property (@(posedge clk) disable iff (srst)
      wrap |=> (b_q == $past(b_ld)));
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
   parameter int M_LO    = 32,
   parameter int AW      = 7,
   parameter int BW      = 11,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          srst,
   input  logic          mode_sel,
   input  logic [AW-1:0] swallow_a,
   input  logic [BW-1:0] main_b,
   output logic          pulse_out,
   output logic          cfg_err
);
   localparam int M_HI   = 2 * M_LO;
   localparam int LG_LO  = $clog2(M_LO);
   localparam int LG_HI  = LG_LO + 1;
   localparam int NW     = BW + LG_HI + 1;
   localparam logic [NW-1:0] FLOOR_LO = NW'(M_LO * (M_LO - 1));
   localparam logic [NW-1:0] FLOOR_HI = NW'(M_HI * (M_HI - 1));

   generate
      if (M_LO < 2 || (M_LO & (M_LO - 1)) != 0) begin : g_bad_m
         $error("M_LO must be a power of two");
      end
      if (AW < 1 || BW < 2 || AW > BW) begin : g_bad_w
         $error("counter widths out of range");
      end
   endgenerate

   pwdiv_pkg::modsel_e act_mode;
   logic               err_q;
   logic               mod_up;
   logic               pre_tc;
   logic               wrap;
   logic               load;
   logic [NW-1:0]      n_req;
   logic [NW-1:0]      floor_req;
   logic               bad_req;

   assign load = srst || wrap;

   always_comb begin
      n_req     = (NW'(main_b) << (mode_sel ? LG_HI : LG_LO)) + NW'(swallow_a);
      floor_req = mode_sel ? FLOOR_HI : FLOOR_LO;
      bad_req   = (BW'(swallow_a) > main_b) || (n_req < floor_req);
   end

   always_ff @(posedge clk) begin
      if (load) begin
         act_mode <= mode_sel ? pwdiv_pkg::MOD_HI : pwdiv_pkg::MOD_LO;
         err_q    <= bad_req;
      end
   end
   assign cfg_err = err_q;

   pwdiv_prescaler #(.M_LO(M_LO)) u_pre (
      .clk    (clk),
      .srst   (srst),
      .mode   (act_mode),
      .mod_up (mod_up),
      .tc     (pre_tc)
   );

   pwdiv_counters #(.AW(AW), .BW(BW)) u_cnt (
      .clk    (clk),
      .srst   (srst),
      .adv    (pre_tc),
      .a_ld   (swallow_a),
      .b_ld   (main_b),
      .mod_up (mod_up),
      .wrap   (wrap)
   );

   generate
      if (REG_OUT) begin : g_reg_out
         logic pulse_q;
         always_ff @(posedge clk) begin
            if (srst) pulse_q <= 1'b0;
            else      pulse_q <= wrap;
         end
         assign pulse_out = pulse_q;
      end else begin : g_comb_out
         assign pulse_out = wrap && !srst;
      end
   endgenerate

   // R4: pulse never lasts two clocks
   p_one_wide_r4: assert property (@(posedge clk) disable iff (srst)
      pulse_out |=> !pulse_out);
   // R6: modulus in use only changes at a period boundary
   p_mode_hold_r6: assert property (@(posedge clk) disable iff (srst)
      !wrap |=> $stable(act_mode));
   // R7: the range flag only changes when a setting is taken into use
   p_err_hold_r7: assert property (@(posedge clk) disable iff (srst)
      !wrap |=> $stable(err_q));
endmodule

// File: tb/pulse_swallow_div_bench.sv
`timescale 1ns/1ps
module pulse_swallow_div_bench;
   localparam int AW = 7;
   localparam int BW = 11;

   logic          clk = 1'b0;
   logic          srst;
   logic          mode_sel;
   logic [AW-1:0] sw_a;
   logic [BW-1:0] mn_b;
   logic          pulse_out;
   logic          cfg_err;

   always #2.5 clk = ~clk;

   pulse_swallow_div u_pulse_swallow_div (
      .clk       (clk),
      .srst      (srst),
      .mode_sel  (mode_sel),
      .swallow_a (sw_a),
      .main_b    (mn_b),
      .pulse_out (pulse_out),
      .cfg_err   (cfg_err)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string tag = "R1";
   int    mdl_cnt = 0;
   bit    mdl_pulse = 1'b0;
   bit    mdl_err = 1'b0;
   bit    started = 1'b0;

   function automatic int ratio_now();
      return (mode_sel ? 64 : 32) * int'(mn_b) + int'(sw_a);
   endfunction

   function automatic bit bad_now();
      int m = mode_sel ? 64 : 32;
      return (int'(mn_b) < int'(sw_a)) || (ratio_now() < m * (m - 1));
   endfunction

   task automatic check(string t, string what, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, what, act, exp, $time);
      end
   endtask

   // behavioural countdown model: one period = N clocks
   always @(posedge clk) begin
      started <= 1'b1;
      if (srst) begin
         mdl_cnt   = ratio_now();
         mdl_pulse = 1'b0;
         mdl_err   = bad_now();
      end else begin
         mdl_cnt = mdl_cnt - 1;
         if (mdl_cnt == 0) begin
            mdl_pulse = 1'b1;
            mdl_cnt   = ratio_now();
            mdl_err   = bad_now();
         end else begin
            mdl_pulse = 1'b0;
         end
      end
   end

   always @(negedge clk) begin
      if (started) begin
         check(tag, "pulse_out", pulse_out, mdl_pulse);
         check(tag, "cfg_err", cfg_err, mdl_err);
      end
   end

   task automatic set_cfg(bit m, int b, int a);
      mode_sel = m;
      mn_b     = BW'(b);
      sw_a     = AW'(a);
   endtask

   task automatic wait_pulses(int k);
      int seen = 0;
      while (seen < k) begin
         @(negedge clk);
         if (pulse_out) seen++;
      end
   endtask

   task automatic wait_last_clock();
      do @(negedge clk); while (mdl_cnt != 1);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      finish_run();
   end

   initial begin
      srst = 1'b1;
      set_cfg(1'b0, 31, 0);
      repeat (3) @(negedge clk);
      // R1: reset holds the output low; R8 floor for M=32 flags no error
      check("R1", "pulse_out in reset", pulse_out, 1'b0);
      check("R8", "cfg_err floor32", cfg_err, 1'b0);

      // R7: B < A is flagged while loading in reset
      set_cfg(1'b0, 40, 50);
      repeat (2) @(negedge clk);
      check("R7", "cfg_err B<A", cfg_err, 1'b1);
      // R7: N under the 64/65 floor
      set_cfg(1'b1, 20, 0);
      repeat (2) @(negedge clk);
      check("R7", "cfg_err below floor", cfg_err, 1'b1);
      // R7: just under the 32/33 floor (B=30, A=31 -> B<A too); B=30,A=30 -> 990
      set_cfg(1'b0, 30, 30);
      repeat (2) @(negedge clk);
      check("R7", "cfg_err 990", cfg_err, 1'b1);

      tag = "R8 R2 R4";
      set_cfg(1'b0, 31, 0);
      @(negedge clk);
      srst = 1'b0;
      wait_pulses(3);

      // R6: change in the middle of a period; R2 and R5 with nonzero A
      tag = "R6 R2 R5";
      repeat (300) @(negedge clk);
      set_cfg(1'b0, 100, 17);
      wait_pulses(3);

      // R6: change in the last clock of a period; R9 with A = B
      tag = "R6 R9";
      wait_last_clock();
      set_cfg(1'b0, 40, 40);
      wait_pulses(3);

      // R3 and R8: floor for M=64, taken at a period end
      tag = "R3 R8 R6";
      wait_last_clock();
      set_cfg(1'b1, 63, 0);
      wait_pulses(2);

      tag = "R3 R5";
      repeat (1000) @(negedge clk);
      set_cfg(1'b1, 70, 5);
      wait_pulses(2);

      // R1: reset mid-period and restart with a new ratio
      tag = "R1 R2";
      repeat (200) @(negedge clk);
      srst = 1'b1;
      set_cfg(1'b0, 35, 3);
      repeat (2) @(negedge clk);
      check("R1", "pulse_out in reset", pulse_out, 1'b0);
      srst = 1'b0;
      wait_pulses(2);

      finish_run();
   end
endmodule